// File: doc/BRIEF.md
# Trigger Coincidence Window Controller

This block sequences the short interval between a front-end trigger and the start of an analog readout. It selects one trigger source, pulls an active-low service request, and opens an acceptance window. While that window is open, neighbouring logic may still add hit channels. When the window closes, the block raises a freeze signal so that the set of hit channels stays fixed. It then opens a second window and waits for an external coincidence pulse. If a coincidence arrives, hold is raised and a one-cycle readout start is issued. If none arrives, a one-master-period reset goes to the peak detectors and the logic, and the block returns to idle.

The logic runs on a clock at twice the master-clock rate. The master-clock level arrives as a sampled input, so the block can see rising and falling master edges on consecutive fast cycles. The acceptance window counts both kinds of master edge. The coincidence window counts rising master edges only.

Top module: `trig_coinc_ctrl`

## Requirements
- R1: The active trigger source is `ext_trig` when `ext_sel`=1. When `ext_sel`=0 it is `volt_or` if `src_sel`=0 and `curr_disc` if `src_sel`=1. A source that is not selected has no effect.
- R2: `srq_n` goes low on the fast cycle after the active trigger is sampled high in idle. It stays low until the block is idle again.
- R3: The acceptance window starts on the first falling master edge after the trigger is taken. It closes on the `gate_cfg`-th master edge after that falling edge, counting rising and falling edges alike. A setting of 0 closes it on the starting falling edge. `freeze` rises on the cycle after it closes.
- R4: `freeze` is low in idle and while the acceptance window is open. It stays high from the close of that window until the block is idle again.
- R5: The coincidence window opens on the first rising master edge strictly after the acceptance window closes. It closes on the `delay_cfg`-th rising edge after the opening edge. A setting of 0 closes it on the opening edge itself.
- R6: If `coinc` is sampled high on any fast cycle from the opening edge through the closing edge, `hold` rises on the cycle after the close. `rd_start` is high for exactly that first cycle.
- R7: `hold` stays high until `rd_done` is sampled high. The block is idle on the following cycle.
- R8: If no `coinc` is sampled in that span, `lrst` is high for two fast cycles (one master period) after the close. The block is then idle.
- R9: Triggers sampled while the block is not idle are ignored.
- R10: While `rst_n` is low, `srq_n`=1 and `freeze`, `hold`, `rd_start` and `lrst` are 0.
- R11: `hold` and `lrst` are never high together, and `rd_start` is only high while `hold` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the master-clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| mclk_lvl | input | 1 | Sampled level of the master clock |
| volt_or | input | 1 | OR of the voltage comparators |
| curr_disc | input | 1 | Current discriminator output |
| ext_trig | input | 1 | External trigger |
| src_sel | input | 1 | Internal source select: 0 voltage OR, 1 current discriminator |
| ext_sel | input | 1 | 0 internal trigger, 1 external trigger |
| coinc | input | 1 | Coincidence pulse |
| gate_cfg | input | GATE_W | Acceptance window length in master edges |
| delay_cfg | input | DELAY_W | Coincidence window length in rising master edges |
| rd_done | input | 1 | Readout finished |
| srq_n | output | 1 | Active-low service request |
| freeze | output | 1 | Hit-channel set frozen |
| hold | output | 1 | Peak hold / readout in progress |
| rd_start | output | 1 | One-cycle readout start |
| lrst | output | 1 | Reset to peak detectors and logic |

## Verification
Each result falls due a fixed number of fast cycles after the trigger sample T. The service request falls on the cycle after T. Freeze rises at T+1+gate. The coincidence window opens one or two cycles later, depending on which master edge closed the acceptance window. It closes 2·delay cycles after it opens. Hold, readout start and reset follow on the cycle after that close. The bench computes these offsets from the gate and delay settings for every run. It samples all outputs on the falling fast edge after each rising edge, one sample per cycle. Coincidence pulses are placed on the opening edge, on the closing edge, and one cycle before the opening edge.

// File: rtl/tcw_pkg.sv
package tcw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ARM   = 3'd1,
      ST_WINA  = 3'd2,
      ST_WAITB = 3'd3,
      ST_WINB  = 3'd4,
      ST_HOLD  = 3'd5,
      ST_RST   = 3'd6
   } tcw_state_e;
endpackage

// File: rtl/tcw_mclk_edge.sv
module tcw_mclk_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mclk_lvl,
   output logic rise,
   output logic fall
);
   logic lvl;
   logic lvl_q;

   initial begin
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4)
         $fatal(1, "tcw_mclk_edge: SYNC_STAGES out of range");
   end

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl = mclk_lvl;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr <= '0;
            end else begin
               sr[0] <= mclk_lvl;
               for (int i = 1; i < SYNC_STAGES; i++) sr[i] <= sr[i-1];
            end
         end
         assign lvl = sr[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;
   assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/tcw_trig_sel.sv
module tcw_trig_sel (
   input  logic volt_or,
   input  logic curr_disc,
   input  logic ext_trig,
   input  logic src_sel,
   input  logic ext_sel,
   output logic trig
);
   logic int_trig;
   always_comb begin
      int_trig = src_sel ? curr_disc : volt_or;
      trig     = ext_sel ? ext_trig : int_trig;
   end
endmodule

// File: rtl/tcw_win_cnt.sv
module tcw_win_cnt #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         run,
   input  logic         step,
   input  logic [W-1:0] limit,
   output logic         done
);
   localparam int WX = W + 1;
   logic [W-1:0]  cnt;
   logic [WX-1:0] nxt;

   initial begin
      if (W < 1 || W > 16) $fatal(1, "tcw_win_cnt: W out of range");
   end

   assign nxt  = {1'b0, cnt} + WX'(1);
   assign done = run & step & (nxt == {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (clr)         cnt <= '0;
      else if (run && step) cnt <= nxt[W-1:0];
   end

   // R3 / R5: a running window never counts past its setting
   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && limit != '0) |-> (cnt < limit));
endmodule

// File: rtl/tcw_fsm.sv
module tcw_fsm
   import tcw_pkg::*;
#(
   parameter int GATE_W    = 3,
   parameter int DELAY_W   = 4,
   parameter int RST_MCYC  = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trig,
   input  logic               rise,
   input  logic               fall,
   input  logic               coinc,
   input  logic               rd_done,
   input  logic [GATE_W-1:0]  gate_cfg,
   input  logic [DELAY_W-1:0] delay_cfg,
   input  logic               a_done,
   input  logic               b_done,
   output logic               a_clr,
   output logic               a_run,
   output logic               b_clr,
   output logic               b_run,
   output logic               srq_n,
   output logic               freeze,
   output logic               hold,
   output logic               rd_start,
   output logic               lrst
);
   localparam int RST_CLKS = 2 * RST_MCYC;
   localparam int RCW      = $clog2(RST_CLKS + 1);

   tcw_state_e     st, st_n;
   logic           seen, seen_n;
   logic [RCW-1:0] rcnt;
   logic           hold_q;

   initial begin
      if (RST_MCYC < 1) $fatal(1, "tcw_fsm: RST_MCYC must be positive");
   end

   assign a_clr = (st == ST_ARM) & fall;
   assign a_run = (st == ST_WINA);
   assign b_clr = (st == ST_WAITB) & rise;
   assign b_run = (st == ST_WINB);

   always_comb begin
      st_n   = st;
      seen_n = seen;
      unique case (st)
         ST_IDLE:  if (trig) st_n = ST_ARM;
         ST_ARM:   if (fall) st_n = (gate_cfg == '0) ? ST_WAITB : ST_WINA;
         ST_WINA:  if (a_done) st_n = ST_WAITB;
         ST_WAITB: if (rise) begin
                      seen_n = coinc;
                      if (delay_cfg == '0) st_n = coinc ? ST_HOLD : ST_RST;
                      else                 st_n = ST_WINB;
                   end
         ST_WINB:  begin
                      if (coinc) seen_n = 1'b1;
                      if (b_done) st_n = (seen || coinc) ? ST_HOLD : ST_RST;
                   end
         ST_HOLD:  if (rd_done) st_n = ST_IDLE;
         ST_RST:   if (rcnt == RCW'(RST_CLKS - 1)) st_n = ST_IDLE;
         default:  st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         seen   <= 1'b0;
         rcnt   <= '0;
         hold_q <= 1'b0;
      end else begin
         st     <= st_n;
         seen   <= seen_n;
         rcnt   <= (st == ST_RST) ? rcnt + RCW'(1) : '0;
         hold_q <= (st == ST_HOLD);
      end
   end

   assign srq_n    = (st == ST_IDLE);
   assign freeze   = !(st == ST_IDLE || st == ST_ARM || st == ST_WINA);
   assign hold     = (st == ST_HOLD);
   assign rd_start = (st == ST_HOLD) & ~hold_q;
   assign lrst     = (st == ST_RST);

   p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(hold && lrst));
   p_start_in_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_start |-> hold);
   p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_start |=> !rd_start);
   p_hold_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !rd_done) |=> hold);
   p_hold_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && rd_done) |=> (srq_n && !hold));
   p_freeze_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |-> !srq_n);
   p_rst_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lrst) |=> lrst);
   p_rst_then_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lrst) |-> srq_n);
endmodule

// File: rtl/trig_coinc_ctrl.sv
module trig_coinc_ctrl #(
   parameter int GATE_W      = 3,
   parameter int DELAY_W     = 4,
   parameter int RST_MCYC    = 1,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mclk_lvl,
   input  logic               volt_or,
   input  logic               curr_disc,
   input  logic               ext_trig,
   input  logic               src_sel,
   input  logic               ext_sel,
   input  logic               coinc,
   input  logic [GATE_W-1:0]  gate_cfg,
   input  logic [DELAY_W-1:0] delay_cfg,
   input  logic               rd_done,
   output logic               srq_n,
   output logic               freeze,
   output logic               hold,
   output logic               rd_start,
   output logic               lrst
);
   logic rise, fall, trig;
   logic a_clr, a_run, a_done;
   logic b_clr, b_run, b_done;
   logic any_edge;

   assign any_edge = rise | fall;

   tcw_mclk_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .mclk_lvl(mclk_lvl), .rise(rise), .fall(fall));

   tcw_trig_sel u_sel (
      .volt_or(volt_or), .curr_disc(curr_disc), .ext_trig(ext_trig),
      .src_sel(src_sel), .ext_sel(ext_sel), .trig(trig));

   tcw_win_cnt #(.W(GATE_W)) u_cnt_a (
      .clk(clk), .rst_n(rst_n), .clr(a_clr), .run(a_run), .step(any_edge),
      .limit(gate_cfg), .done(a_done));

   tcw_win_cnt #(.W(DELAY_W)) u_cnt_b (
      .clk(clk), .rst_n(rst_n), .clr(b_clr), .run(b_run), .step(rise),
      .limit(delay_cfg), .done(b_done));

   tcw_fsm #(.GATE_W(GATE_W), .DELAY_W(DELAY_W), .RST_MCYC(RST_MCYC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .trig(trig), .rise(rise), .fall(fall),
      .coinc(coinc), .rd_done(rd_done), .gate_cfg(gate_cfg),
      .delay_cfg(delay_cfg), .a_done(a_done), .b_done(b_done),
      .a_clr(a_clr), .a_run(a_run), .b_clr(b_clr), .b_run(b_run),
      .srq_n(srq_n), .freeze(freeze), .hold(hold), .rd_start(rd_start),
      .lrst(lrst));
endmodule

// File: tb/tb_trig_coinc_ctrl.sv
module tb_trig_coinc_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mclk_lvl = 1'b0;
   logic volt_or = 1'b0, curr_disc = 1'b0, ext_trig = 1'b0;
   logic src_sel = 1'b0, ext_sel = 1'b0, coinc = 1'b0, rd_done = 1'b0;
   logic [2:0] gate_cfg = '0;
   logic [3:0] delay_cfg = '0;
   logic srq_n, freeze, hold, rd_start, lrst;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   trig_coinc_ctrl dut (
      .clk(clk), .rst_n(rst_n), .mclk_lvl(mclk_lvl), .volt_or(volt_or),
      .curr_disc(curr_disc), .ext_trig(ext_trig), .src_sel(src_sel),
      .ext_sel(ext_sel), .coinc(coinc), .gate_cfg(gate_cfg),
      .delay_cfg(delay_cfg), .rd_done(rd_done), .srq_n(srq_n),
      .freeze(freeze), .hold(hold), .rd_start(rd_start), .lrst(lrst));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (gate=%0d delay=%0d)",
                  req, act, exp, gate_cfg, delay_cfg);
      end
   endtask

   task automatic step();
      @(negedge clk);
      mclk_lvl = ~mclk_lvl;
   endtask

   task automatic drive_src(input int m, input logic v);
      if (m == 0) volt_or = v;
      else if (m == 1) curr_disc = v;
      else ext_trig = v;
   endtask

   task automatic run_case(input int g, input int d, input int cmode, input int srcm);
      int o, e, cn, idle_n;
      bit hit;
      gate_cfg  = 3'(g);
      delay_cfg = 4'(d);
      ext_sel   = (srcm == 2);
      src_sel   = (srcm == 1);
      // R1: pulse the two unselected sources, the request must stay high
      step();
      for (int k = 0; k < 3; k++) if (k != srcm) drive_src(k, 1'b1);
      step();
      for (int k = 0; k < 3; k++) drive_src(k, 1'b0);
      step();
      step();
      chk(srq_n == 1'b1, "R1 unselected source", int'(srq_n), 1);
      // align so the trigger is sampled on a rising master edge
      do step(); while (mclk_lvl != 1'b1);
      drive_src(srcm, 1'b1);
      o   = 1 + g + ((g % 2 == 1) ? 2 : 1);
      e   = o + 2 * d;
      cn  = (cmode == 0) ? -1 : (cmode == 1) ? o - 1 : (cmode == 2) ? e - 1 : o - 2;
      hit = (cmode == 1) || (cmode == 2);
      idle_n = hit ? e + 3 : e + 2;
      for (int n = 0; n <= e + 5; n++) begin
         step();
         chk(srq_n == (n >= idle_n), "R2 srq_n", int'(srq_n), int'(n >= idle_n));
         chk(freeze == (n >= 1 + g && n < idle_n), "R3/R4 freeze",
             int'(freeze), int'(n >= 1 + g && n < idle_n));
         chk(hold == (hit && n >= e && n < idle_n), "R5/R6/R7 hold",
             int'(hold), int'(hit && n >= e && n < idle_n));
         chk(rd_start == (hit && n == e), "R6 rd_start", int'(rd_start), int'(hit && n == e));
         chk(lrst == (!hit && n >= e && n < idle_n), "R5/R8 lrst",
             int'(lrst), int'(!hit && n >= e && n < idle_n));
         chk(!(hold && lrst) && (!rd_start || hold), "R11 exclusive", int'({hold, lrst, rd_start}), 0);
         // R9: retrigger while busy, must not change the expected sequence
         drive_src(srcm, (n == 1 || n == e) ? 1'b1 : 1'b0);
         coinc   = (n == cn);
         rd_done = hit && (n == e + 2);
      end
      coinc = 1'b0;
      rd_done = 1'b0;
      drive_src(srcm, 1'b0);
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) step();
      // R10 reset state, with a trigger present during reset
      volt_or = 1'b1;
      step();
      chk(srq_n == 1'b1, "R10 srq_n", int'(srq_n), 1);
      chk({freeze, hold, rd_start, lrst} == 4'b0, "R10 outputs", int'({freeze, hold, rd_start, lrst}), 0);
      volt_or = 1'b0;
      step();
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) step();
      for (int g = 0; g < 8; g++)
         for (int d = 0; d < 16; d++)
            for (int cm = 0; cm < 4; cm++)
               run_case(g, d, cm, (g + d + cm) % 3);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule